// File: doc/BRIEF.md
# Serial EEPROM Slave (64 x 16)

This block is a synthesizable stand-in for a small serial EEPROM of 64 words of 16 bits. A host drives a three-wire interface: a chip select, a serial clock and a data input. The block answers on a data output that comes with an output enable. All three inputs are brought into the system clock domain through two-flop synchronizers. Serial clock edges are detected there, so the serial clock must run well below the system clock.

Each transaction opens with a single 1 bit. A two-bit command follows, then a six-bit word address, then sixteen data bits when the command carries data. A read returns one leading zero and then streams words from the addressed one onward, wrapping past the top of the array, until chip select drops. Programming commands are held back by a write-enable latch and take effect on the falling edge of chip select. Programming is followed by a self-timed busy period of a parameterised number of system clocks. During that period, raising chip select shows busy or ready on the data output.

The array is a register file that resets to all ones. Reset stands in for power-up: it clears the write-enable latch and returns the array to the erased state.

Top module: `mw_eeprom_slave`

## Requirements
- R1: A frame is a 1 start bit, a 2-bit command, a 6-bit address (MSB first), then 16 data bits (MSB first) for the write and write-all commands. Commands: 10 read, 01 write word, 11 erase word, 00 extended. For extended, the top two address bits select: 11 enable writes, 00 disable writes, 01 write all, 10 erase all.
- R2: A read drives a 0 after the serial clock rise that takes in the last address bit. It then drives the 16 data bits MSB first, each one changing only after a rising serial clock edge, with the output enable high.
- R3: After the last bit of a word, a read continues with the next address with no extra zero, and wraps from address 63 to address 0 for as long as chip select stays high.
- R4: The write-enable latch is clear after reset. Write, erase, write-all and erase-all leave the array unchanged while it is clear. Enable sets the latch and disable clears it.
- R5: A programming command takes effect only on the falling edge of chip select that ends its frame, and a write stores its data word at its address.
- R6: Erase sets the addressed word to 16'hFFFF. Erase-all sets every word to 16'hFFFF. Write-all stores its data word in all 64 words.
- R7: After programming starts, raising chip select drives the data output with the output enable high: 0 while the PROG_CYCLES busy period runs, 1 once it has ended.
- R8: The status display is cleared by a rising serial clock edge that finds chip select and data input both high. It is not shown at all if chip select rises only after the busy period has ended.
- R9: When more than 16 data bits arrive before chip select falls, the last 16 received are stored.
- R10: A frame that starts while programming is busy is ignored and changes no word.
- R11: After reset the output enable is low and every word reads 16'hFFFF. The output enable is low whenever no read data or status is being shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset (power-up) |
| cs_i | input | 1 | Chip select, active high, asynchronous to clk |
| sk_i | input | 1 | Serial clock from the host, asynchronous to clk |
| di_i | input | 1 | Serial data input |
| do_o | output | 1 | Serial data output: read data or ready/busy status |
| do_oe_o | output | 1 | Output enable for do_o; low means high impedance |

## Verification
Two functions can fall on the same serial clock edge. The edge that clears a ready status (chip select and data input high) is also the start bit of the next frame. The bench provokes this by raising chip select after programming and pulsing the serial clock once with the data input high. It then judges that the output enable has dropped and that no word was changed when the half-received frame was abandoned. The second overlap is a new frame sent while the busy period is still running. It is judged by reading back both the address being programmed and the address the ignored frame targeted.

// File: rtl/mw_eeprom_pkg.sv
// Package: shared command codes and decoder state for the serial EEPROM slave.
// Assumes: command field is two bits; extended sub-command sits in the top two
// address bits.
package mw_eeprom_pkg;

    typedef enum logic [1:0] {
        CMD_EXT   = 2'b00,
        CMD_WRITE = 2'b01,
        CMD_READ  = 2'b10,
        CMD_ERASE = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {
        SUB_LOCK  = 2'b00,
        SUB_FILL  = 2'b01,
        SUB_CLEAR = 2'b10,
        SUB_UNLK  = 2'b11
    } sub_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_DATA,
        ST_READ,
        ST_HOLD
    } st_e;

endpackage

// File: rtl/mw_sync.sv
// Module: multi-bit, multi-stage synchronizer for independent asynchronous
// control inputs. Assumes: each bit is an unrelated level signal; a reset
// value of zero is safe for all of them.
module mw_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift the sampled inputs one stage further along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain[s] <= '0;
                end else if (s == 0) begin
                    chain[s] <= d;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s - 1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/mw_prog_timer.sv
// Module: self-timed programming counter. Assumes: start is a one-cycle
// pulse never issued while busy; busy rises the cycle after start and stays
// high for CYCLES system clocks.
module mw_prog_timer #(
    parameter int CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] remain;

    // Load on start, then count the busy window down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (start) begin
            remain <= CNT_W'(CYCLES);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy = (remain != '0);

endmodule

// File: rtl/mw_word_array.sv
// Module: register-file storage of WORDS x DATA_W with one write port that
// hits a single word or all words, and one combinational read port.
// Assumes: reset models the erased state (all ones).
module mw_word_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              we_all,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int WORDS = 1 << ADDR_W;

    logic [WORDS-1:0][DATA_W-1:0] words;

    genvar i;
    generate
        for (i = 0; i < WORDS; i++) begin : g_word
            logic [DATA_W-1:0] word_q;
            // Update this word when the write targets it or all words.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    word_q <= '1;
                end else if (we && (we_all || waddr == ADDR_W'(i))) begin
                    word_q <= wdata;
                end
            end
            assign words[i] = word_q;
        end
    endgenerate

    assign rdata = words[raddr];

endmodule

// File: rtl/mw_eeprom_slave.sv
// Module: serial EEPROM slave top. Decodes frames sampled on serial clock
// rises, streams reads with auto-increment, guards programming with a
// write-enable latch, commits on chip-select fall and reports ready/busy.
// Assumes: sk_i is slow enough that every level lasts at least three clk
// cycles; cs_i, sk_i and di_i are asynchronous to clk.
module mw_eeprom_slave #(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2,
    parameter int PROG_CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    output logic do_o,
    output logic do_oe_o
);
    import mw_eeprom_pkg::*;

    localparam int HDR_W  = 2 + ADDR_W;
    localparam int HCNT_W = $clog2(HDR_W + 1);
    localparam int DCNT_W = $clog2(DATA_W + 1);
    localparam int BCNT_W = $clog2(DATA_W);

    // ---------------- input synchronization and edges ----------------
    logic [2:0] pins_s;
    logic       cs_s, sk_s, di_s;
    logic       cs_d, sk_d;
    logic       sk_rise, cs_rise, cs_fall;

    mw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_i, sk_i, di_i}),
        .q     (pins_s)
    );

    assign {cs_s, sk_s, di_s} = pins_s;

    // Remember previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_d <= 1'b0;
            sk_d <= 1'b0;
        end else begin
            cs_d <= cs_s;
            sk_d <= sk_s;
        end
    end

    assign sk_rise = sk_s & ~sk_d;
    assign cs_rise = cs_s & ~cs_d;
    assign cs_fall = ~cs_s & cs_d;

    // ---------------- decoder state ----------------
    st_e               state;
    logic [HDR_W-2:0]  hdr_sr;
    logic [HCNT_W-1:0] hdr_cnt;
    logic [DATA_W-1:0] data_sr;
    logic [DCNT_W-1:0] data_cnt;
    logic [ADDR_W-1:0] pend_addr;
    logic              pend_all;
    logic              pend_erase;
    logic              pend_valid;
    logic              wen_q;
    logic [DATA_W-1:0] rd_sr;
    logic [BCNT_W-1:0] rd_cnt;
    logic [ADDR_W-1:0] rd_addr;
    logic              dout_q;
    logic              armed_q;

    logic [HDR_W-1:0]  hdr_next;
    cmd_e              cmd;
    logic [ADDR_W-1:0] adr;
    sub_e              sub;
    logic              hdr_last;
    logic              busy;
    logic              prog_start;
    logic              rd_active;
    logic [ADDR_W-1:0] arr_raddr;
    logic [DATA_W-1:0] arr_rdata;
    logic [DATA_W-1:0] arr_wdata;

    assign hdr_next = {hdr_sr, di_s};
    assign cmd      = cmd_e'(hdr_next[HDR_W-1 -: 2]);
    assign adr      = hdr_next[ADDR_W-1:0];
    assign sub      = sub_e'(adr[ADDR_W-1 -: 2]);
    assign hdr_last = (hdr_cnt == HCNT_W'(HDR_W - 1));

    // A frame is committed only by the chip-select fall that closes it.
    assign prog_start = cs_fall && wen_q &&
                        ((state == ST_DATA && data_cnt == DCNT_W'(DATA_W)) ||
                         (state == ST_HOLD && pend_valid));

    assign rd_active = (state == ST_READ);
    assign arr_raddr = (state == ST_HDR) ? adr : rd_addr;
    assign arr_wdata = pend_erase ? '1 : data_sr;

    // Frame sequencer: start bit, header, data, read stream and latch control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            hdr_sr     <= '0;
            hdr_cnt    <= '0;
            data_sr    <= '0;
            data_cnt   <= '0;
            pend_addr  <= '0;
            pend_all   <= 1'b0;
            pend_erase <= 1'b0;
            pend_valid <= 1'b0;
            wen_q      <= 1'b0;
            rd_sr      <= '0;
            rd_cnt     <= '0;
            rd_addr    <= '0;
            dout_q     <= 1'b0;
        end else if (!cs_s) begin
            state      <= ST_IDLE;
            hdr_cnt    <= '0;
            data_cnt   <= '0;
            pend_valid <= 1'b0;
        end else if (sk_rise) begin
            case (state)
                ST_IDLE: begin
                    if (di_s && !busy) begin
                        state   <= ST_HDR;
                        hdr_cnt <= '0;
                    end
                end
                ST_HDR: begin
                    hdr_sr  <= hdr_next[HDR_W-2:0];
                    hdr_cnt <= hdr_cnt + 1'b1;
                    if (hdr_last) begin
                        case (cmd)
                            CMD_READ: begin
                                state   <= ST_READ;
                                dout_q  <= 1'b0;
                                rd_sr   <= arr_rdata;
                                rd_addr <= adr + ADDR_W'(1);
                                rd_cnt  <= '0;
                            end
                            CMD_WRITE: begin
                                state      <= ST_DATA;
                                pend_addr  <= adr;
                                pend_all   <= 1'b0;
                                pend_erase <= 1'b0;
                                data_cnt   <= '0;
                            end
                            CMD_ERASE: begin
                                state      <= ST_HOLD;
                                pend_addr  <= adr;
                                pend_all   <= 1'b0;
                                pend_erase <= 1'b1;
                                pend_valid <= 1'b1;
                            end
                            default: begin
                                case (sub)
                                    SUB_UNLK: begin
                                        wen_q <= 1'b1;
                                        state <= ST_HOLD;
                                    end
                                    SUB_LOCK: begin
                                        wen_q <= 1'b0;
                                        state <= ST_HOLD;
                                    end
                                    SUB_FILL: begin
                                        state      <= ST_DATA;
                                        pend_all   <= 1'b1;
                                        pend_erase <= 1'b0;
                                        data_cnt   <= '0;
                                    end
                                    default: begin
                                        state      <= ST_HOLD;
                                        pend_all   <= 1'b1;
                                        pend_erase <= 1'b1;
                                        pend_valid <= 1'b1;
                                    end
                                endcase
                            end
                        endcase
                    end
                end
                ST_DATA: begin
                    data_sr <= {data_sr[DATA_W-2:0], di_s};
                    if (data_cnt != DCNT_W'(DATA_W)) begin
                        data_cnt <= data_cnt + 1'b1;
                    end
                end
                ST_READ: begin
                    dout_q <= rd_sr[DATA_W-1];
                    rd_cnt <= rd_cnt + 1'b1;
                    if (rd_cnt == BCNT_W'(DATA_W - 1)) begin
                        rd_sr   <= arr_rdata;
                        rd_addr <= rd_addr + ADDR_W'(1);
                    end else begin
                        rd_sr <= {rd_sr[DATA_W-2:0], 1'b0};
                    end
                end
                default: ;
            endcase
        end
    end

    // Status display arming: set by a commit, dropped by clear edge or late CS.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (prog_start) begin
            armed_q <= 1'b1;
        end else if (cs_s && sk_rise && di_s) begin
            armed_q <= 1'b0;
        end else if (cs_rise && !busy) begin
            armed_q <= 1'b0;
        end
    end

    mw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (prog_start),
        .busy  (busy)
    );

    mw_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (prog_start),
        .we_all (pend_all),
        .waddr  (pend_addr),
        .wdata  (arr_wdata),
        .raddr  (arr_raddr),
        .rdata  (arr_rdata)
    );

    assign do_oe_o = cs_s && (rd_active || armed_q);
    assign do_o    = rd_active ? dout_q : !busy;

endmodule

// File: rtl/mw_eeprom_checker.sv
// Module: protocol checker for the serial EEPROM slave, attached by bind.
// Assumes: connected to the top's internal timer, latch and read signals.
module mw_eeprom_checker (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic prog_start,
    input logic wen_q,
    input logic rd_active,
    input logic do_o,
    input logic do_oe_o
);

    AST_LOCKED_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!wen_q && !busy) |=> !busy); // R4

    AST_COMMIT_STARTS_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> busy); // R5

    AST_STATUS_BUSY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && do_oe_o && !rd_active) |-> !do_o); // R7

    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !prog_start); // R10

    AST_READ_DUMMY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_active) |-> !do_o); // R2

endmodule

bind mw_eeprom_slave mw_eeprom_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .prog_start (prog_start),
    .wen_q      (wen_q),
    .rd_active  (rd_active),
    .do_o       (do_o),
    .do_oe_o    (do_oe_o)
);

// File: tb/mw_eeprom_slave_tb.sv
// Scoreboard bench: driver tasks push expected read bits into a queue; a
// monitor pops and compares them at each sample point.
module mw_eeprom_slave_tb;

    localparam int PROG = 400;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0;
    logic sk = 1'b0;
    logic di = 1'b0;
    logic do_w;
    logic oe_w;

    int n_chk = 0;
    int n_fail = 0;

    logic  exp_q [$];
    string tag_q [$];
    logic [15:0] model [64];
    event smp_ev;

    always #2.5 clk = ~clk;

    mw_eeprom_slave #(.PROG_CYCLES(PROG)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_i    (cs),
        .sk_i    (sk),
        .di_i    (di),
        .do_o    (do_w),
        .do_oe_o (oe_w)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sk_pulse(input logic d, input bit samp);
        di = d;
        tick(HALF);
        sk = 1'b1;
        tick(HALF);
        if (samp) -> smp_ev;
        sk = 1'b0;
    endtask

    task automatic cs_up();
        cs = 1'b1;
        tick(HALF);
    endtask

    task automatic cs_down();
        cs = 1'b0;
        di = 1'b0;
        tick(HALF);
    endtask

    // R1: start bit, 2-bit command, 6-bit address, MSB first.
    task automatic send_hdr(input logic [1:0] c, input logic [5:0] a, input bit samp_last);
        sk_pulse(1'b1, 1'b0);
        sk_pulse(c[1], 1'b0);
        sk_pulse(c[0], 1'b0);
        for (int i = 5; i >= 0; i--) sk_pulse(a[i], samp_last && i == 0);
    endtask

    task automatic send_word(input logic [15:0] d);
        for (int i = 15; i >= 0; i--) sk_pulse(d[i], 1'b0);
    endtask

    task automatic op_write(input logic [5:0] a, input logic [15:0] d, input bit wait_done);
        cs_up();
        send_hdr(2'b01, a, 1'b0);
        send_word(d);
        cs_down();
        if (wait_done) tick(PROG + 20);
    endtask

    task automatic op_short(input logic [1:0] c, input logic [5:0] a, input bit wait_done);
        cs_up();
        send_hdr(c, a, 1'b0);
        cs_down();
        if (wait_done) tick(PROG + 20);
    endtask

    // Driver: push the dummy zero and n words from the model, then clock them.
    task automatic read_words(input logic [5:0] a, input int n, input string tag);
        exp_q.push_back(1'b0);
        tag_q.push_back({tag, " dummy"});
        for (int w = 0; w < n; w++) begin
            logic [15:0] word;
            word = model[6'(a + w)];
            for (int b = 15; b >= 0; b--) begin
                exp_q.push_back(word[b]);
                tag_q.push_back(tag);
            end
        end
        cs_up();
        send_hdr(2'b10, a, 1'b1);
        for (int k = 0; k < n * 16; k++) sk_pulse(1'b0, 1'b1);
        cs_down();
        chk(exp_q.size() == 0, {tag, " queue drained"}, exp_q.size(), 0);
    endtask

    // Monitor: compare data out against the scoreboard at every sample point.
    initial begin
        forever begin
            @(smp_ev);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected sample", do_w, 0);
            end else begin
                logic  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(oe_w === 1'b1 && do_w === e, t, {oe_w, do_w}, {1'b1, e});
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        chk(oe_w == 1'b0, "R11 reset output enable", oe_w, 0);

        read_words(6'd5, 1, "R11 R1 R2 erased read");

        // R4: locked after reset, write ignored.
        op_write(6'd5, 16'h1234, 1'b1);
        read_words(6'd5, 1, "R4 locked write");

        op_short(2'b00, 6'b110000, 1'b0);

        // R5 R7 R8: write, watch busy then ready, clear by SK with DI high.
        op_write(6'd5, 16'hA5C3, 1'b0);
        model[5] = 16'hA5C3;
        cs = 1'b1;
        tick(8);
        chk(oe_w == 1'b1 && do_w == 1'b0, "R7 busy status", {oe_w, do_w}, 2'b10);
        tick(PROG);
        chk(oe_w == 1'b1 && do_w == 1'b1, "R7 ready status", {oe_w, do_w}, 2'b11);
        sk_pulse(1'b1, 1'b0);
        tick(2);
        chk(oe_w == 1'b0, "R8 status cleared", oe_w, 0);
        cs_down();
        read_words(6'd5, 1, "R5 write stored");

        // R3: stream across the top of the array.
        op_write(6'd63, 16'h1111, 1'b1);
        model[63] = 16'h1111;
        op_write(6'd0, 16'h2222, 1'b1);
        model[0] = 16'h2222;
        read_words(6'd63, 3, "R3 wrap stream");

        // R9: 20 data bits, last 16 kept.
        cs_up();
        send_hdr(2'b01, 6'd7, 1'b0);
        sk_pulse(1'b1, 1'b0);
        sk_pulse(1'b0, 1'b0);
        sk_pulse(1'b1, 1'b0);
        sk_pulse(1'b0, 1'b0);
        send_word(16'h3C5A);
        cs_down();
        model[7] = 16'h3C5A;
        tick(PROG + 20);
        read_words(6'd7, 1, "R9 overlong data");

        // R10: frame during busy is ignored.
        op_write(6'd20, 16'hBEEF, 1'b0);
        model[20] = 16'hBEEF;
        op_write(6'd21, 16'h0BAD, 1'b1);
        read_words(6'd21, 1, "R10 busy frame ignored");
        read_words(6'd20, 1, "R10 first write kept");

        // R8: CS raised only after the busy period shows no status.
        op_write(6'd30, 16'h0F0F, 1'b1);
        model[30] = 16'h0F0F;
        cs = 1'b1;
        tick(8);
        chk(oe_w == 1'b0, "R8 late CS no status", oe_w, 0);
        cs_down();

        // R6: erase one word.
        op_short(2'b11, 6'd5, 1'b1);
        model[5] = 16'hFFFF;
        read_words(6'd5, 1, "R6 erase word");

        // R4: disable then write ignored, enable again.
        op_short(2'b00, 6'b000000, 1'b0);
        op_write(6'd40, 16'h7777, 1'b1);
        read_words(6'd40, 1, "R4 disabled write");
        op_short(2'b00, 6'b111111, 1'b0);

        // R6: write all, then erase all.
        cs_up();
        send_hdr(2'b00, 6'b010000, 1'b0);
        send_word(16'h5A5A);
        cs_down();
        tick(PROG + 20);
        for (int i = 0; i < 64; i++) model[i] = 16'h5A5A;
        read_words(6'd62, 2, "R6 write all");
        op_short(2'b00, 6'b100000, 1'b1);
        for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
        read_words(6'd10, 1, "R6 erase all");

        tick(4);
        chk(oe_w == 1'b0, "R11 idle output enable", oe_w, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule